// File: doc/BRIEF.md
# Modulo Timer Counter with Overflow Flag

The block is a timer counter with a programmable modulus. It advances once for each cycle in which the counting-enable input is high. It has two counting modes.

- **Up mode.** The counter climbs to its limit and then returns to zero.
- **Up/down mode.** The counter climbs to the limit, turns and descends to zero, then climbs again. This gives a symmetric, centre-aligned period.

A modulus of zero selects the full counter range. At the end of every period the block sets an overflow flag. The interrupt output is a level: the flag ANDed with an enable bit.

Software reaches the block through a small register port. Reads are combinational and writes are strobed. The flag is cleared in two steps. First, read the control register while the flag is set; this arms the clear. Then write the control register with the flag bit at zero. An overflow that lands between the two steps cancels the armed clear, so that event is not lost.

Top module: `mod_timer`

## Requirements
- R1: After reset the count, the modulus and all control bits are zero, and irq_o is low. Register map:
  - address 0 is control, with bit 0 = mode (1 = up/down), bit 1 = interrupt enable and bit 2 = overflow flag;
  - address 1 is modulus;
  - address 2 is the count, which is read-only.
- R2: In up mode with a modulus of 0, the count runs from 0x0000 to 0xFFFF. The next tick takes it to 0x0000 and sets the flag.
- R3: In up mode with a nonzero modulus M, a tick at count M (or above) takes the count to 0 and sets the flag. Below M, a tick adds one.
- R4: In up/down mode, while rising, a tick at the top value takes the count to top−1 and sets the flag. The top value is the modulus, or 0xFFFF when the modulus is 0.
- R5: In up/down mode, while falling, a tick at count 0 takes the count to 1 and turns upward. The flag is not set.
- R6: The count does not change in a cycle where tick_i is low.
- R7: The flag clears when two things happen in order:
  - a read of address 0 while the flag is 1;
  - a later write to address 0 with bit 2 = 0.
  
  Any write to address 0 ends the armed state.
- R8: A write of 0 to bit 2 without a preceding armed read leaves the flag at 1. A write of 1 to bit 2 never sets the flag.
- R9: An overflow between the arming read and the clearing write cancels the clear, and the flag stays 1.
- R10: irq_o is high exactly when the flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counting enable, one count per high cycle |
| addr_i | input | 2 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| cnt_o | output | 16 | Current count |
| irq_o | output | 1 | Overflow interrupt level |

## Verification
The assertions assume that each cycle carries at most one register access, either a read or a write. They also assume the modulus is only changed while the counter sits at or below the new value. With both assumptions in place, the wrap and turn properties describe real period ends.

The stimulus issues every access through single-cycle tasks, and it never asserts tick_i during an access cycle. It reprograms the modulus only at counts that stay within the new limit. The one mode change from up/down to up is made at a count equal to the new modulus, which the up-mode wrap handles as a normal wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MOD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
  localparam int B_MODE = 0;
  localparam int B_IE   = 1;
  localparam int B_FLAG = 2;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         updown_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] ALL = '1;

  logic [W-1:0] cnt_q, cnt_d, top;
  logic         down_q, down_d, ovf;

  assign top = (mod_i == '0) ? ALL : mod_i;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    ovf    = 1'b0;
    if (!updown_i) begin
      down_d = 1'b0;
      if (tick_i) begin
        if (cnt_q >= top) begin
          cnt_d = '0;
          ovf   = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
    end else if (tick_i) begin
      if (!down_q) begin
        if (cnt_q >= top) begin
          down_d = 1'b1;
          cnt_d  = cnt_q - ONE;
          ovf    = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (cnt_q == '0) begin
        down_d = 1'b0;
        cnt_d  = ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf;

  // R6
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
  // R3
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !updown_i && mod_i != '0 && cnt_o == mod_i) |=> (cnt_o == '0));
  // R4
  turn_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && updown_i && !down_q && cnt_o == top && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - ONE));
  // R5
  turn_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && updown_i && down_q && cnt_o == '0) |=> (cnt_o == ONE && !down_q));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic rd_ctrl_i,
  input  logic wr_ctrl_i,
  input  logic wr_flag_bit_i,
  output logic flag_o
);
  logic flag_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (ovf_i)
        flag_q <= 1'b1;
      else if (wr_ctrl_i && !wr_flag_bit_i && armed_q)
        flag_q <= 1'b0;

      // a new overflow or any control write ends the clear sequence
      if (ovf_i || wr_ctrl_i)
        armed_q <= 1'b0;
      else if (rd_ctrl_i && flag_q)
        armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  // R9
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_o);
  // R8
  flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(wr_ctrl_i && !wr_flag_bit_i && !ovf_i));
  // R7
  armed_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(rd_ctrl_i && flag_o));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      cnt_i,
  input  logic              flag_i,
  output logic              mode_o,
  output logic              ie_o,
  output logic [W-1:0]      mod_o,
  output logic              rd_ctrl_o,
  output logic              wr_ctrl_o,
  output logic [W-1:0]      rdata_o
);
  logic         mode_q, ie_q;
  logic [W-1:0] mod_q;

  assign wr_ctrl_o = wr_i && (addr_i == A_CTRL);
  assign rd_ctrl_o = rd_i && (addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ie_q   <= 1'b0;
      mod_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == A_CTRL) begin
        mode_q <= wdata_i[B_MODE];
        ie_q   <= wdata_i[B_IE];
      end else if (addr_i == A_MOD) begin
        mod_q <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[B_MODE] = mode_q;
        rdata_o[B_IE]   = ie_q;
        rdata_o[B_FLAG] = flag_i;
      end
      A_MOD:   rdata_o = mod_q;
      A_CNT:   rdata_o = cnt_i;
      default: rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign ie_o   = ie_q;
  assign mod_o  = mod_q;

  // R1
  mod_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_MOD) |=> (mod_o == $past(wdata_i)));
endmodule

// File: rtl/mod_timer.sv
module mod_timer
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      cnt_o,
  output logic              irq_o
);
  logic         mode, ie, flag, ovf, rd_ctrl, wr_ctrl;
  logic [W-1:0] modv, cnt;

  tmr_regs #(.W(W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .cnt_i(cnt), .flag_i(flag), .mode_o(mode), .ie_o(ie),
    .mod_o(modv), .rd_ctrl_o(rd_ctrl), .wr_ctrl_o(wr_ctrl), .rdata_o(rdata_o)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .updown_i(mode),
    .mod_i(modv), .cnt_o(cnt), .ovf_o(ovf)
  );

  tmr_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .ovf_i(ovf), .rd_ctrl_i(rd_ctrl),
    .wr_ctrl_i(wr_ctrl), .wr_flag_bit_i(wdata_i[B_FLAG]), .flag_o(flag)
  );

  assign cnt_o = cnt;
  assign irq_o = flag & ie;

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie |-> !irq_o);
endmodule

// File: tb/mod_timer_test.sv
module mod_timer_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        tick;
    logic [15:0] cnt;
    logic        flg;
  } vec_t;

  // up/down mode, modulus 3, starting at 0
  localparam vec_t VECS [10] = '{
    '{1'b1, 16'd1, 1'b0}, '{1'b0, 16'd1, 1'b0}, '{1'b1, 16'd2, 1'b0},
    '{1'b1, 16'd3, 1'b0}, '{1'b1, 16'd2, 1'b1}, '{1'b1, 16'd1, 1'b1},
    '{1'b1, 16'd0, 1'b1}, '{1'b1, 16'd1, 1'b1}, '{1'b0, 16'd1, 1'b1},
    '{1'b1, 16'd2, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, cnt;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mod_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .rd_i(rd),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .cnt_o(cnt), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_reg(2'd0, d); chk("R1 ctrl", d, 0);
    rd_reg(2'd1, d); chk("R1 mod", d, 0);
    rd_reg(2'd2, d); chk("R1 cnt", d, 0);
    chk("R1 irq", irq, 0);
    // R6 no ticks, no motion
    repeat (4) @(negedge clk);
    chk("R6 hold", cnt, 0);

    // R4 R5 table walk in up/down mode
    wr_reg(2'd0, 16'h0001);
    wr_reg(2'd1, 16'd3);
    for (int i = 0; i < 10; i++) begin
      ticks(VECS[i].tick ? 1 : 0);
      if (!VECS[i].tick) @(negedge clk);
      rd_reg(2'd2, d); chk($sformatf("R4/R5 cnt step %0d", i), d, VECS[i].cnt);
      rd_reg(2'd0, d); chk($sformatf("R4/R5 flag step %0d", i), d[2], VECS[i].flg);
    end

    // R7 armed clear (last read saw flag=1), R10 gating
    wr_reg(2'd0, 16'h0003);
    chk("R7 cleared", irq, 0);
    rd_reg(2'd0, d); chk("R7 flag bit", d[2], 0);

    // R3 up mode, modulus 2, count at 2
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd1, 16'd2);
    ticks(1); chk("R3 wrap cnt", cnt, 0);
    ticks(2); chk("R3 count up", cnt, 2);
    ticks(1); chk("R3 wrap again", cnt, 0);
    // R8 write 0 with no armed read
    wr_reg(2'd0, 16'h0002);
    chk("R8 flag kept", irq, 1);
    chk("R10 irq on", irq, 1);
    wr_reg(2'd0, 16'h0000);
    chk("R10 irq masked", irq, 0);
    wr_reg(2'd0, 16'h0006);
    chk("R8 write1 keeps", irq, 1);

    // R9 event between read and write
    rd_reg(2'd0, d); chk("R9 flag seen", d[2], 1);
    ticks(3); chk("R9 wrapped", cnt, 0);
    wr_reg(2'd0, 16'h0002);
    chk("R9 flag stays", irq, 1);
    rd_reg(2'd0, d);
    wr_reg(2'd0, 16'h0002);
    chk("R7 clear after rearm", irq, 0);
    wr_reg(2'd0, 16'h0006);
    chk("R8 write1 no set", irq, 0);

    // R2 full range
    wr_reg(2'd1, 16'd0);
    ticks(65535);
    chk("R2 top", cnt, 16'hFFFF);
    chk("R2 no flag yet", irq, 0);
    ticks(1);
    chk("R2 wrap", cnt, 0);
    chk("R2 flag", irq, 1);
    finish_run();
  end
endmodule